// File: doc/BRIEF.md
# SCSI Interrupt Status Register

This block collects five bus-controller events into a sticky 8-bit status word. A host can read the word and be interrupted by it. Each event input sets its own bit, and the bit stays set until the host reads the word. A read returns the bits that were set and clears them in the same step. An event that lands in the cycle of the read is kept for the following read. A per-bit mask selects which bits drive the interrupt-pending output.

Bit 7 has two meanings, chosen by the operating mode. As initiator, the block samples the bus phase on the rising edge of the request line. Bit 7 sets if that phase differs from the phase the running instruction expects. As target, bit 7 sets when the initiator raises attention. The selected and reselected bits set only when the matching response enable is on and the addressed ID equals this device's own ID. The block also watches the spacing between host reads. A read that comes fewer than the minimum number of clocks after the previous one raises a violation flag.

Top module: `scsi_irq_status`

## Requirements
- R1: After reset, rd_data is 0x00, irq is low and rd_too_soon is low; the first read after reset never raises rd_too_soon.
- R2: With tgt_mode low (initiator), bit 7 sets when req_in rises and bus_phase differs from exp_phase in that cycle. A rising edge with matching phases does not set it. A phase change while req_in stays high does not set it either.
- R3: With tgt_mode high (target), bit 7 sets when atn_in rises, and request edges with mismatched phases are ignored. With tgt_mode low, atn_in edges are ignored.
- R4: Bit 6 (function complete) sets on a pulse of either arb_only_done or arb_full_done.
- R5: Bit 5 (selected) sets on sel_try only when sel_en is high and sel_id equals own_id.
- R6: Bit 4 (reselected) sets on resel_try only when resel_en is high and sel_id equals own_id.
- R7: Bit 3 (gross error) sets on a fifo_underrun strobe, which marks a read of the empty FIFO.
- R8: rd_data shows the status combinationally. A cycle with rd_en high clears every bit that is set in that cycle. An event arriving in the same cycle as the read is set for the next read.
- R9: Bits 2 to 0 of rd_data always read as zero.
- R10: irq is high exactly when some status bit is set and its irq_mask bit is 1.
- R11: rd_too_soon is high during a read that comes fewer than 12 cycles after the previous read. A read 12 or more cycles after the previous one leaves it low.
- R12: A set status bit keeps its value across idle cycles until a read clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tgt_mode | input | 1 | 1 = target mode, 0 = initiator mode |
| exp_phase | input | PHASE_W | Phase the current instruction expects |
| bus_phase | input | PHASE_W | Phase driven on the bus by the target |
| req_in | input | 1 | Synchronous request line |
| atn_in | input | 1 | Synchronous attention line |
| arb_only_done | input | 1 | Arbitration-only sequence finished (pulse) |
| arb_full_done | input | 1 | Full arbitration sequence finished (pulse) |
| sel_try | input | 1 | Selection attempt seen (pulse) |
| resel_try | input | 1 | Reselection attempt seen (pulse) |
| sel_id | input | ID_W | ID addressed by the attempt |
| own_id | input | ID_W | This device's ID |
| sel_en | input | 1 | Respond-to-selection enable |
| resel_en | input | 1 | Respond-to-reselection enable |
| fifo_underrun | input | 1 | FIFO read while empty (pulse) |
| rd_en | input | 1 | Host read strobe, one cycle per read |
| irq_mask | input | 8 | Per-bit interrupt enable |
| rd_data | output | 8 | Status word |
| irq | output | 1 | Interrupt pending |
| rd_too_soon | output | 1 | Read spacing violation |

## Verification
If a status flop holds a wrong value, the fault shows on rd_data and, through the mask, on irq in the cycle after the event that should have set it. The bench reads the word in the next cycle, so a lost or spurious bit appears there. A broken edge register shows up in two ways: a held request line sets bit 7 again, or a real edge is missed. Both are visible at the first read after the stimulus. A miscounting spacing counter shows up on rd_too_soon at the second read of a pair placed at 11 and 12 cycles.

// File: rtl/scsi_irq_status.sv
module scsi_irq_status #(
  parameter int ID_W    = 4,
  parameter int PHASE_W = 3,
  parameter int RD_GAP  = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tgt_mode,
  input  logic [PHASE_W-1:0] exp_phase,
  input  logic [PHASE_W-1:0] bus_phase,
  input  logic               req_in,
  input  logic               atn_in,
  input  logic               arb_only_done,
  input  logic               arb_full_done,
  input  logic               sel_try,
  input  logic               resel_try,
  input  logic [ID_W-1:0]    sel_id,
  input  logic [ID_W-1:0]    own_id,
  input  logic               sel_en,
  input  logic               resel_en,
  input  logic               fifo_underrun,
  input  logic               rd_en,
  input  logic [7:0]         irq_mask,
  output logic [7:0]         rd_data,
  output logic               irq,
  output logic               rd_too_soon
);
  localparam int CW = $clog2(RD_GAP + 1);
  localparam logic [CW-1:0] GAP_MAX = CW'(RD_GAP);

  logic          req_q, atn_q;
  logic          req_rise, atn_rise, id_hit;
  logic [4:0]    stat, set_v;
  logic [CW-1:0] gap_cnt;

  assign req_rise = req_in & ~req_q;
  assign atn_rise = atn_in & ~atn_q;
  assign id_hit   = (sel_id == own_id);

  assign set_v[4] = tgt_mode ? atn_rise : (req_rise && (bus_phase != exp_phase));
  assign set_v[3] = arb_only_done | arb_full_done;
  assign set_v[2] = sel_try & sel_en & id_hit;
  assign set_v[1] = resel_try & resel_en & id_hit;
  assign set_v[0] = fifo_underrun;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_q <= 1'b0;
      atn_q <= 1'b0;
      stat  <= '0;
    end else begin
      req_q <= req_in;
      atn_q <= atn_in;
      stat  <= rd_en ? set_v : (stat | set_v);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      gap_cnt <= GAP_MAX;
    else if (rd_en)
      gap_cnt <= CW'(1);
    else if (gap_cnt < GAP_MAX)
      gap_cnt <= gap_cnt + CW'(1);
  end

  assign rd_data     = {stat, 3'b000};
  assign irq         = |(rd_data & irq_mask);
  assign rd_too_soon = rd_en && (gap_cnt < GAP_MAX);
endmodule

// File: rtl/scsi_irq_status_chk.sv
module scsi_irq_status_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       rd_en,
  input logic       sel_en,
  input logic       fifo_underrun,
  input logic [7:0] irq_mask,
  input logic [7:0] rd_data,
  input logic       irq,
  input logic       rd_too_soon
);
  AST_SPARE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[2:0] == 3'b000); // R9
  AST_UNDERRUN_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_underrun |=> rd_data[3]); // R7
  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && !fifo_underrun |=> !rd_data[3]); // R8
  AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[6] && !rd_en |=> rd_data[6]); // R12
  AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    irq_mask == 8'h00 |-> !irq); // R10
  AST_BACK_TO_BACK: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && $past(rd_en) |-> rd_too_soon); // R11
  AST_SEL_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_data[5] && !sel_en |=> !rd_data[5]); // R5
endmodule

bind scsi_irq_status scsi_irq_status_chk u_chk (
  .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .sel_en(sel_en),
  .fifo_underrun(fifo_underrun), .irq_mask(irq_mask),
  .rd_data(rd_data), .irq(irq), .rd_too_soon(rd_too_soon)
);

// File: tb/tb_scsi_irq_status.sv
`timescale 1ns/1ps
module tb_scsi_irq_status;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tgt_mode = 1'b0;
  logic [2:0] exp_phase = '0, bus_phase = '0;
  logic req_in = 1'b0, atn_in = 1'b0;
  logic arb_only_done = 1'b0, arb_full_done = 1'b0;
  logic sel_try = 1'b0, resel_try = 1'b0;
  logic [3:0] sel_id = 4'd0, own_id = 4'd5;
  logic sel_en = 1'b0, resel_en = 1'b0;
  logic fifo_underrun = 1'b0, rd_en = 1'b0;
  logic [7:0] irq_mask = 8'hFF;
  logic [7:0] rd_data;
  logic irq, rd_too_soon;

  int checks = 0;
  int fails = 0;

  always #2 clk = ~clk;

  scsi_irq_status dut (
    .clk(clk), .rst_n(rst_n), .tgt_mode(tgt_mode),
    .exp_phase(exp_phase), .bus_phase(bus_phase),
    .req_in(req_in), .atn_in(atn_in),
    .arb_only_done(arb_only_done), .arb_full_done(arb_full_done),
    .sel_try(sel_try), .resel_try(resel_try),
    .sel_id(sel_id), .own_id(own_id),
    .sel_en(sel_en), .resel_en(resel_en),
    .fifo_underrun(fifo_underrun), .rd_en(rd_en), .irq_mask(irq_mask),
    .rd_data(rd_data), .irq(irq), .rd_too_soon(rd_too_soon)
  );

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got 0x%02h expected 0x%02h", tag, got, exp);
    end
  endtask

  task automatic do_read(output logic [7:0] v, output logic ts);
    @(negedge clk) rd_en = 1'b1;
    #1 v = rd_data; ts = rd_too_soon;
    @(negedge clk) rd_en = 1'b0;
  endtask

  task automatic read_expect(input string tag, input logic [7:0] exp);
    logic [7:0] v;
    logic ts;
    do_read(v, ts);
    chk(tag, v, exp);
  endtask

  task automatic pulse(ref logic s);
    @(negedge clk) s = 1'b1;
    @(negedge clk) s = 1'b0;
  endtask

  task automatic t_reset;
    logic [7:0] v;
    logic ts;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 status", rd_data, 8'h00);
    chk("R1 irq", {7'd0, irq}, 8'h00);
    chk("R1 too_soon idle", {7'd0, rd_too_soon}, 8'h00);
    do_read(v, ts);
    chk("R1 first read flag", {7'd0, ts}, 8'h00);
  endtask

  task automatic t_initiator;
    tgt_mode = 1'b0;
    @(negedge clk) exp_phase = 3'd2; bus_phase = 3'd2; req_in = 1'b1;
    @(negedge clk) req_in = 1'b0;
    read_expect("R2 matching phase", 8'h00);
    @(negedge clk) bus_phase = 3'd3; req_in = 1'b1;
    @(negedge clk);
    read_expect("R2 mismatch on edge", 8'h80);
    @(negedge clk) bus_phase = 3'd6;
    @(negedge clk);
    read_expect("R2 held request no edge", 8'h00);
    @(negedge clk) req_in = 1'b0; bus_phase = 3'd2;
  endtask

  task automatic t_target;
    tgt_mode = 1'b0;
    @(negedge clk) atn_in = 1'b1;
    @(negedge clk) atn_in = 1'b0;
    read_expect("R3 attention ignored as initiator", 8'h00);
    tgt_mode = 1'b1;
    @(negedge clk) atn_in = 1'b1;
    @(negedge clk) atn_in = 1'b0;
    read_expect("R3 attention as target", 8'h80);
    @(negedge clk) bus_phase = 3'd7; req_in = 1'b1;
    @(negedge clk) req_in = 1'b0;
    read_expect("R3 request ignored as target", 8'h00);
    tgt_mode = 1'b0; bus_phase = 3'd2;
  endtask

  task automatic t_arb;
    pulse(arb_only_done);
    read_expect("R4 arbitration only", 8'h40);
    pulse(arb_full_done);
    read_expect("R4 full arbitration", 8'h40);
  endtask

  task automatic t_sel;
    sel_id = own_id; sel_en = 1'b1;
    pulse(sel_try);
    read_expect("R5 selected", 8'h20);
    sel_en = 1'b0;
    pulse(sel_try);
    read_expect("R5 disabled", 8'h00);
    sel_en = 1'b1; sel_id = 4'd3;
    pulse(sel_try);
    read_expect("R5 id mismatch", 8'h00);
    sel_en = 1'b0;
  endtask

  task automatic t_resel;
    sel_id = own_id; resel_en = 1'b1;
    pulse(resel_try);
    read_expect("R6 reselected", 8'h10);
    resel_en = 1'b0;
    pulse(resel_try);
    read_expect("R6 disabled", 8'h00);
    resel_en = 1'b1; sel_id = 4'd9;
    pulse(resel_try);
    read_expect("R6 id mismatch", 8'h00);
    resel_en = 1'b0;
  endtask

  task automatic t_underrun;
    pulse(fifo_underrun);
    read_expect("R7 underrun", 8'h08);
  endtask

  task automatic t_read_race;
    logic [7:0] v;
    logic ts;
    pulse(fifo_underrun);
    @(negedge clk) rd_en = 1'b1; arb_only_done = 1'b1;
    #1 v = rd_data;
    @(negedge clk) rd_en = 1'b0; arb_only_done = 1'b0;
    chk("R8 read returns old", v, 8'h08);
    read_expect("R8 same-cycle event kept", 8'h40);
    read_expect("R8 cleared", 8'h00);
  endtask

  task automatic t_all_bits;
    tgt_mode = 1'b1; sel_id = own_id; sel_en = 1'b1; resel_en = 1'b1;
    @(negedge clk) atn_in = 1'b1; arb_full_done = 1'b1; sel_try = 1'b1;
    resel_try = 1'b1; fifo_underrun = 1'b1;
    @(negedge clk) atn_in = 1'b0; arb_full_done = 1'b0; sel_try = 1'b0;
    resel_try = 1'b0; fifo_underrun = 1'b0;
    chk("R9 low bits zero all set", rd_data, 8'hF8);
    read_expect("R9 read all", 8'hF8);
    tgt_mode = 1'b0; sel_en = 1'b0; resel_en = 1'b0;
  endtask

  task automatic t_irq;
    pulse(arb_only_done);
    irq_mask = 8'h00; #1;
    chk("R10 all masked", {7'd0, irq}, 8'h00);
    irq_mask = 8'h40; #1;
    chk("R10 bit6 enabled", {7'd0, irq}, 8'h01);
    irq_mask = 8'hBF; #1;
    chk("R10 other bits enabled", {7'd0, irq}, 8'h00);
    irq_mask = 8'hFF;
    read_expect("R10 drain", 8'h40);
    #1 chk("R10 irq after read", {7'd0, irq}, 8'h00);
  endtask

  task automatic t_sticky;
    sel_id = own_id; sel_en = 1'b1;
    pulse(sel_try);
    sel_en = 1'b0;
    repeat (20) @(negedge clk);
    chk("R12 held", rd_data, 8'h20);
    read_expect("R12 read", 8'h20);
  endtask

  task automatic t_spacing;
    logic [7:0] v;
    logic ts;
    repeat (15) @(negedge clk);
    do_read(v, ts);
    chk("R11 spaced read", {7'd0, ts}, 8'h00);
    repeat (9) @(negedge clk);
    do_read(v, ts);
    chk("R11 gap 11 flagged", {7'd0, ts}, 8'h01);
    repeat (10) @(negedge clk);
    do_read(v, ts);
    chk("R11 gap 12 clean", {7'd0, ts}, 8'h00);
    do_read(v, ts);
    chk("R11 back to back", {7'd0, ts}, 8'h01);
  endtask

  initial begin
    t_reset();
    t_initiator();
    t_target();
    t_arb();
    t_sel();
    t_resel();
    t_underrun();
    t_read_race();
    t_all_bits();
    t_irq();
    t_sticky();
    t_spacing();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #(4 * 200000);
    checks++;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule